// File: doc/BRIEF.md
# Vertical Line-Skip Sequencer for Overlay Downscaling

This block picks the source lines of a video overlay that are passed on, so the overlay can be shrunk vertically by a ratio between 1 and 1/2. It uses a fractional phase accumulator, a digital differential analyzer. Each time the downstream formatter asks for a line, the block presents the current source line number with a one-cycle valid strobe. It then moves its line pointer forward by one. When the fractional phase add overflows, the pointer moves forward by one more, so that source line is never fetched.

A 32-bit control register holds the 14-bit step fraction in its upper bits. Software computes the step as `((original_lines << 14) / scaled_lines) << 18`, truncated to 32 bits. Only the fractional part of the ratio survives that truncation, because the pointer always supplies the whole line. A vertical-retrace strobe restarts the frame. It also loads the step that the frame will use, so a register write in mid-frame cannot disturb the frame in flight. A separate enable input turns the skipping on and off.

Top module: `vline_dda_seq`

## Requirements
- R1: After reset, `reg_rdata_o` is 0x00000000, `line_vld_o` is 0 and `line_num_o` is 0.
- R2: A write stores bits 31:18 (the step fraction) and bits 15 and 11:0 (side control fields that have no function in this block). Bits 17:16 and 14:12 always read as zero, whatever value is written to them. A written value with the default parameters therefore reads back as `wdata & 0xFFFC8FFF`, from the cycle after the write edge.
- R3: A vertical-retrace strobe clears the phase and the skip flag and sets the line pointer to 0. The first line requested after a retrace is always line 0. If a retrace and a line request arrive in the same cycle, the retrace wins and no line is produced.
- R4: While `ds_en_i` is low, successive requested lines are numbered 0, 1, 2, … with no skipping, and the phase is held.
- R5: While `ds_en_i` is high, each requested line first sends the current pointer. The block then forms the 15-bit sum phase + step. The low 14 bits become the new phase, and the pointer advances by 1 plus the carry bit of that sum.
- R6: The step used in a frame is the register value captured at that frame's retrace. A step written in mid-frame takes effect only from the next retrace.
- R7: The 11-bit line pointer saturates at 2047 and does not wrap. Once it reaches 2047, any further requested lines are all numbered 2047.
- R8: A line request that is accepted on a clock edge raises `line_vld_o` for exactly one cycle after that edge, carrying the line number. `line_vld_o` is never high in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vretrace_i | input | 1 | Vertical-retrace strobe, restarts the frame |
| line_adv_i | input | 1 | Request for the next output line |
| ds_en_i | input | 1 | Downscale enable; when low, every line is sent |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 32 | Control register write data |
| reg_rdata_o | output | 32 | Control register read-back |
| line_num_o | output | 11 | Source line number for the formatter |
| line_vld_o | output | 1 | One-cycle strobe marking `line_num_o` valid |

## Verification
`line_num_o` and `line_vld_o` change on the clock edge that accepts a request, which is one register stage. `reg_rdata_o` reflects a write from the edge that captures it. A retrace changes no output directly; its effect shows on the next line produced. The bench drives inputs on falling edges and samples on the next falling edge. A scoreboard queues one expected line number per request when the request is driven, and pops the queue each time the strobe is seen. Missing, extra and misnumbered lines are all caught this way. Register read-back is compared half a cycle after the write edge.

// File: rtl/vline_dda_pkg.sv
package vline_dda_pkg;
   localparam int REG_W = 32;
   // side control fields kept by the register: bit 15 and bits 11:0
   localparam logic [REG_W-1:0] SIDE_MASK = 32'h0000_8FFF;

   function automatic logic [REG_W-1:0] step_mask(input int frac_w);
      step_mask = {REG_W{1'b1}} << (REG_W - frac_w);
   endfunction
endpackage

// File: rtl/vline_dda_cfg_reg.sv
module vline_dda_cfg_reg
   import vline_dda_pkg::*;
#(
   parameter int FRAC_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [REG_W-1:0]  wdata_i,
   output logic [REG_W-1:0]  rdata_o,
   output logic [FRAC_W-1:0] step_o
);
   localparam logic [REG_W-1:0] KEEP_MASK = step_mask(FRAC_W) | SIDE_MASK;

   logic [REG_W-1:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cfg_q <= '0;
      else if (wr_i) cfg_q <= wdata_i & KEEP_MASK;
   end

   assign rdata_o = cfg_q;
   assign step_o  = cfg_q[REG_W-1 -: FRAC_W];
endmodule

// File: rtl/vline_dda_phase.sv
module vline_dda_phase #(
   parameter int FRAC_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vretrace_i,
   input  logic              adv_i,
   input  logic              ds_en_i,
   input  logic [FRAC_W-1:0] step_i,
   output logic              skip_o,
   output logic [FRAC_W-1:0] step_act_o
);
   logic [FRAC_W-1:0] phase_q;
   logic [FRAC_W-1:0] step_q;
   logic [FRAC_W:0]   sum;

   assign sum    = {1'b0, phase_q} + {1'b0, step_q};
   assign skip_o = ds_en_i & sum[FRAC_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         step_q  <= '0;
      end else if (vretrace_i) begin
         phase_q <= '0;
         step_q  <= step_i;
      end else if (adv_i && ds_en_i) begin
         phase_q <= sum[FRAC_W-1:0];
      end
   end

   assign step_act_o = step_q;
endmodule

// File: rtl/vline_dda_ptr.sv
module vline_dda_ptr #(
   parameter int LINE_W   = 11,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vretrace_i,
   input  logic              adv_i,
   input  logic              skip_i,
   output logic [LINE_W-1:0] ptr_o,
   output logic [LINE_W-1:0] line_num_o,
   output logic              line_vld_o
);
   localparam logic [LINE_W-1:0] PTR_MAX = '1;

   logic [LINE_W-1:0] ptr_q, ptr_nxt, num_q;
   logic [LINE_W:0]   ext;
   logic              vld_q;

   assign ext = {1'b0, ptr_q} + {{(LINE_W-1){1'b0}}, skip_i, ~skip_i};

   generate
      if (SATURATE) begin : g_sat
         assign ptr_nxt = ext[LINE_W] ? PTR_MAX : ext[LINE_W-1:0];
      end else begin : g_wrap
         assign ptr_nxt = ext[LINE_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         num_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         if (vretrace_i) begin
            ptr_q <= '0;
         end else if (adv_i) begin
            num_q <= ptr_q;
            vld_q <= 1'b1;
            ptr_q <= ptr_nxt;
         end
      end
   end

   assign ptr_o      = ptr_q;
   assign line_num_o = num_q;
   assign line_vld_o = vld_q;
endmodule

// File: rtl/vline_dda_seq.sv
module vline_dda_seq
   import vline_dda_pkg::*;
#(
   parameter int LINE_W   = 11,
   parameter int FRAC_W   = 14,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vretrace_i,
   input  logic              line_adv_i,
   input  logic              ds_en_i,
   input  logic              reg_wr_i,
   input  logic [31:0]       reg_wdata_i,
   output logic [31:0]       reg_rdata_o,
   output logic [LINE_W-1:0] line_num_o,
   output logic              line_vld_o
);
   generate
      if (FRAC_W < 1 || FRAC_W > 16) begin : g_bad_frac
         $error("vline_dda_seq: FRAC_W must lie in 1..16");
      end
      if (LINE_W < 2) begin : g_bad_line
         $error("vline_dda_seq: LINE_W must be at least 2");
      end
   endgenerate

   logic [FRAC_W-1:0] step_w, step_act_w;
   logic              skip_w;
   logic [LINE_W-1:0] ptr_w;
   logic              adv_w;

   assign adv_w = line_adv_i & ~vretrace_i;

   vline_dda_cfg_reg #(.FRAC_W(FRAC_W)) cfg_i (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
      .rdata_o(reg_rdata_o), .step_o(step_w)
   );

   vline_dda_phase #(.FRAC_W(FRAC_W)) phase_i (
      .clk(clk), .rst_n(rst_n), .vretrace_i(vretrace_i), .adv_i(adv_w),
      .ds_en_i(ds_en_i), .step_i(step_w), .skip_o(skip_w),
      .step_act_o(step_act_w)
   );

   vline_dda_ptr #(.LINE_W(LINE_W), .SATURATE(SATURATE)) ptr_i (
      .clk(clk), .rst_n(rst_n), .vretrace_i(vretrace_i), .adv_i(adv_w),
      .skip_i(skip_w), .ptr_o(ptr_w), .line_num_o(line_num_o),
      .line_vld_o(line_vld_o)
   );
endmodule

// File: rtl/vline_dda_chk.sv
module vline_dda_chk #(
   parameter int LINE_W = 11,
   parameter int FRAC_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vretrace_i,
   input logic              line_adv_i,
   input logic              ds_en_i,
   input logic [31:0]       reg_rdata_o,
   input logic              line_vld_o,
   input logic [LINE_W-1:0] ptr,
   input logic [FRAC_W-1:0] step_act
);
   localparam logic [LINE_W-1:0] PMAX = '1;
   localparam logic [LINE_W-1:0] PMAX1 = PMAX - 1'b1;

   always_comb begin
      if (rst_n) begin
         a_r2_rsvd_zero: assert ((reg_rdata_o & 32'h0003_7000) == 32'h0)
            else $error("reserved bits nonzero");
      end
   end

   a_r3_ptr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      vretrace_i |=> (ptr == '0));

   a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (line_adv_i && !vretrace_i && !ds_en_i && ptr != PMAX) |=>
      (ptr == $past(ptr) + 1'b1));

   a_r5_step_le_two: assert property (@(posedge clk) disable iff (!rst_n)
      (line_adv_i && !vretrace_i && ptr < PMAX1) |=>
      ((ptr == $past(ptr) + 1'b1) || (ptr == $past(ptr) + 2'd2)));

   a_r6_step_frame_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !vretrace_i |=> $stable(step_act));

   a_r7_ptr_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (!vretrace_i && ptr == PMAX) |=> (ptr == PMAX));

   a_r8_vld_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      (line_adv_i && !vretrace_i) |=> line_vld_o);

   a_r8_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_adv_i && !vretrace_i) |=> !line_vld_o);
endmodule

bind vline_dda_seq vline_dda_chk #(.LINE_W(LINE_W), .FRAC_W(FRAC_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .vretrace_i(vretrace_i), .line_adv_i(line_adv_i),
   .ds_en_i(ds_en_i), .reg_rdata_o(reg_rdata_o), .line_vld_o(line_vld_o),
   .ptr(ptr_w), .step_act(step_act_w)
);

// File: tb/vline_dda_seq_tb_top.sv
module vline_dda_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vretrace = 1'b0, line_adv = 1'b0, ds_en = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [10:0] line_num;
   logic        line_vld;

   int checks = 0, errors = 0;
   logic [10:0] exp_q[$];
   string       tag_q[$];

   // bench model
   logic [31:0] m_reg = '0;
   logic [13:0] m_step = '0, m_phase = '0;
   int          m_ptr = 0;

   always #10 clk = ~clk;

   vline_dda_seq dut_i (
      .clk(clk), .rst_n(rst_n), .vretrace_i(vretrace), .line_adv_i(line_adv),
      .ds_en_i(ds_en), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
      .reg_rdata_o(reg_rdata), .line_num_o(line_num), .line_vld_o(line_vld)
   );

   task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", r, act, exp);
      end
   endtask

   // monitor: pop on each strobe
   always @(negedge clk) begin
      if (rst_n && line_vld) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R8 actual strobe expected none (line %0d)", line_num);
         end else begin
            check(tag_q.pop_front(), {21'b0, line_num}, {21'b0, exp_q.pop_front()});
         end
      end
   end

   function automatic logic [31:0] calc_step(input int orig, input int scaled);
      logic [31:0] q;
      q = (orig << 14) / scaled;
      return q << 18;
   endfunction

   task automatic wr_reg(input logic [31:0] d, input string r);
      @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
      m_reg = d & 32'hFFFC_8FFF;
      check(r, reg_rdata, m_reg);
   endtask

   task automatic retrace(input bit with_req);
      @(negedge clk); vretrace = 1'b1; line_adv = with_req;
      m_ptr = 0; m_phase = '0; m_step = m_reg[31:18];
      @(negedge clk); vretrace = 1'b0; line_adv = 1'b0;
   endtask

   task automatic send_lines(input int n, input string r);
      logic [14:0] s;
      for (int i = 0; i < n; i++) begin
         @(negedge clk); line_adv = 1'b1;
         exp_q.push_back(m_ptr[10:0]); tag_q.push_back(r);
         if (ds_en) begin
            s = {1'b0, m_phase} + {1'b0, m_step};
            m_phase = s[13:0];
            m_ptr = m_ptr + 1 + int'(s[14]);
         end else begin
            m_ptr = m_ptr + 1;
         end
         if (m_ptr > 2047) m_ptr = 2047;
      end
      @(negedge clk); line_adv = 1'b0;
      @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL %s actual missing %0d lines expected 0", r, exp_q.size());
         exp_q.delete(); tag_q.delete();
      end
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", reg_rdata, 32'h0);
      check("R1", {31'b0, line_vld}, 32'h0);
      check("R1", {21'b0, line_num}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: reserved bits drop
      wr_reg(32'hFFFF_FFFF, "R2");
      wr_reg(32'h0003_7000, "R2");
      wr_reg(32'h0, "R2");

      // R4: disabled, step set to 0.5
      wr_reg(calc_step(480, 320), "R2");
      check("R2", reg_rdata, 32'h8000_0000);
      ds_en = 1'b0;
      retrace(1'b0);
      send_lines(6, "R4");

      // R5: enabled, several ratios
      ds_en = 1'b1;
      retrace(1'b0);
      send_lines(8, "R5");
      wr_reg(calc_step(480, 400), "R2");
      retrace(1'b0);
      send_lines(12, "R5");
      wr_reg(32'hFFFC_0000, "R2");
      retrace(1'b0);
      send_lines(10, "R5");

      // R6: mid-frame write
      wr_reg(calc_step(480, 400), "R2");
      retrace(1'b0);
      send_lines(5, "R6");
      wr_reg(32'h4000_0000, "R6");
      send_lines(5, "R6");
      retrace(1'b0);
      send_lines(8, "R6");

      // R3: retrace together with request, then first line
      send_lines(3, "R3");
      retrace(1'b1);
      send_lines(1, "R3");

      // R7: saturation with skipping off
      ds_en = 1'b0;
      retrace(1'b0);
      send_lines(2052, "R7");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule